// File: doc/BRIEF.md
# Pixel Colour Index Decoder

This block turns the raw screen data for one pixel into an 8-bit logical colour index for the palette stage that follows it. Each cycle it receives one bit from each of the four video pages, the attribute bytes for the current character cell from the lower and upper page pairs, the flash phase, the 8-bit border colour and a 4-bit decode-mode code. From these it forms the index that the selected interpretation calls for.

Several interpretations are covered. Three are attribute based: classic attributes with bright and flash, split-bright attributes, and a 32-colour attribute mode. Two take whole attribute bytes as colours, with a single layer and with two layers. There are three bitplane modes, in 16-colour, forced-bright 8-colour and 256-colour banked forms. A border-only mode and a 2-bit chunky mode complete the set. The index is registered, so it appears one clock after the inputs are presented. The fetch stage and the palette stage are outside the block, and so are the modes that mix RGB levels.

Top module: `pix_colour_decoder`

## Requirements
- R1: While `rst_n` is low, `colour_idx` is 0. Outside reset, `colour_idx` shows the index computed from the inputs sampled at the previous rising clock edge.
- R2: Mode 0 (classic). Ink is attribute bits 2:0, paper is bits 5:3, bright is bit 6 and flash is bit 7. The index is {0000, bright, ink} when `plane_bits[0]` is 1 and {0000, bright, paper} when it is 0. When flash is 1 and `flash_phase` is 1, ink and paper swap. The attribute comes from `attr_lo` in every attribute mode.
- R3: Mode 1 (split bright). The ink index is {0000, bit 6, ink} and the paper index is {0000, bit 7, paper}, with the same pixel choice as R2. Flash has no effect.
- R4: Mode 2 (32 colour). The index is {000, attr bits 7:6, ink or paper}, with the same pixel choice as R2. Flash has no effect.
- R5: Mode 6 (4-plane). The index is {0000, plane3, plane2, plane1, plane0}. For example, plane0..plane3 = 1,0,1,1 gives 13.
- R6: Mode 7 (3-plane). Plane 1 is ignored. The index is {0000, 1, plane3, plane2, plane0}.
- R7: Mode 4 (256-colour ink). When `plane_bits[0]` is 1 the index is `attr_lo`; otherwise it is `border_idx`.
- R8: Mode 5 (two-layer 256). When `plane_bits[0]` is 1 the index is `attr_lo`. Otherwise, when `plane_bits[2]` is 1, it is `attr_hi`. Otherwise it is `border_idx`.
- R9: Mode 12 (256-colour planar). The index is {attr_lo bits 3:0, plane3, plane2, plane1, plane0}.
- R10: Mode 13 (border only). The index is `border_idx` whatever the pixel and attribute inputs are.
- R11: Mode 14 (chunky). The pair {plane_bits[1], plane_bits[0]} selects the colour. 00 gives the paper index {0000, bright, paper}, 01 gives ink+16, 10 gives ink+24 and 11 gives ink+8. Flash has no effect.
- R12: Every other mode code (3, 8, 9, 10, 11, 15) gives index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| plane_bits | input | 4 | Pixel bit from each video page, bit n from page n |
| attr_lo | input | 8 | Attribute byte of the cell from the lower page pair |
| attr_hi | input | 8 | Attribute byte of the cell from the upper page pair |
| flash_phase | input | 1 | Current flash phase, 1 = swapped |
| border_idx | input | 8 | 8-bit border colour |
| mode | input | 4 | Decode-mode code |
| colour_idx | output | 8 | Registered logical colour index |

## Verification
The only state in this block is the output register. A wrong internal value therefore shows up as a wrong index on the very next clock, and only in the modes whose datapath carries the fault. A fault in the flash swap appears only when flash and phase are both 1. A fault in the overlay priority appears only when both layers are lit. A slip in a chunky offset appears only for one bit pair. For this reason the bench checks every cycle against its model and uses directed vectors to reach each of these corners, in addition to a random sweep.

// File: rtl/pcd_pkg.sv
// Package for the pixel colour decoder.
// It holds the mode codes and the shared widths.
// The mode codes are fixed by the register writer upstream and must not be renumbered.
package pcd_pkg;
    localparam int IDX_W   = 8;
    localparam int ATTR_W  = 8;
    localparam int PLANE_N = 4;

    typedef enum logic [3:0] {
        MODE_CLASSIC   = 4'd0,
        MODE_SPLITBR   = 4'd1,
        MODE_C32       = 4'd2,
        MODE_INK256    = 4'd4,
        MODE_LAYER256  = 4'd5,
        MODE_PLANAR4   = 4'd6,
        MODE_PLANAR3   = 4'd7,
        MODE_PLANAR256 = 4'd12,
        MODE_BORDER    = 4'd13,
        MODE_CHUNKY    = 4'd14
    } mode_e;
endpackage

// File: rtl/pcd_attr_unit.sv
// Attribute interpreter.
// It forms the classic, split-bright, 32-colour and chunky indices from one attribute byte.
// Assumes: the attribute fields are ink[2:0], paper[5:3], b6 and b7.
// The fetch stage presents the chunky pair on pair_i.
module pcd_attr_unit #(
    parameter int IDX_W  = pcd_pkg::IDX_W,
    parameter int ATTR_W = pcd_pkg::ATTR_W
) (
    input  logic              pix_i,
    input  logic [1:0]        pair_i,
    input  logic [ATTR_W-1:0] attr_i,
    input  logic              phase_i,
    output logic [IDX_W-1:0]  classic_o,
    output logic [IDX_W-1:0]  splitbr_o,
    output logic [IDX_W-1:0]  c32_o,
    output logic [IDX_W-1:0]  chunky_o
);
    localparam int PAD4 = IDX_W - 4;
    localparam int PAD5 = IDX_W - 5;

    logic [2:0] ink, paper, fg, bg;
    logic       b6, b7, swap;

    // Split the attribute into its fields.
    always_comb begin
        ink   = attr_i[2:0];
        paper = attr_i[5:3];
        b6    = attr_i[6];
        b7    = attr_i[7];
    end

    // Apply the flash swap (classic mode only).
    always_comb begin
        swap = b7 & phase_i;
        fg   = swap ? paper : ink;
        bg   = swap ? ink   : paper;
    end

    // Classic index: one bright bit shared by ink and paper.
    always_comb begin
        classic_o = {{PAD4{1'b0}}, b6, (pix_i ? fg : bg)};
    end

    // Split-bright index: b6 brightens ink, b7 brightens paper.
    always_comb begin
        splitbr_o = pix_i ? {{PAD4{1'b0}}, b6, ink} : {{PAD4{1'b0}}, b7, paper};
    end

    // 32-colour index: the top two bits pick the bank of eight.
    always_comb begin
        c32_o = {{PAD5{1'b0}}, b7, b6, (pix_i ? ink : paper)};
    end

    // Chunky index: each bit pair picks paper or one of three ink intensities.
    always_comb begin
        unique case (pair_i)
            2'b00:   chunky_o = {{PAD4{1'b0}}, b6, paper};
            2'b01:   chunky_o = {{PAD5{1'b0}}, 2'b10, ink};
            2'b10:   chunky_o = {{PAD5{1'b0}}, 2'b11, ink};
            default: chunky_o = {{PAD5{1'b0}}, 2'b01, ink};
        endcase
    end
endmodule

// File: rtl/pcd_plane_unit.sv
// Bitplane combiner.
// It forms the 16-colour, forced-bright 8-colour and attribute-banked 256-colour indices.
// Assumes: PLANE_N is 4 and IDX_W is at least 2*PLANE_N.
// Plane 0 is the least significant plane.
module pcd_plane_unit #(
    parameter int IDX_W   = pcd_pkg::IDX_W,
    parameter int ATTR_W  = pcd_pkg::ATTR_W,
    parameter int PLANE_N = pcd_pkg::PLANE_N
) (
    input  logic [PLANE_N-1:0] planes_i,
    input  logic [ATTR_W-1:0]  attr_i,
    output logic [IDX_W-1:0]   planar4_o,
    output logic [IDX_W-1:0]   planar3_o,
    output logic [IDX_W-1:0]   planar256_o
);
    localparam int HI_W = IDX_W - PLANE_N;

    logic [PLANE_N-1:0] nib4, nib3;

    // Build both nibbles bit by bit.
    // The 3-plane variant replaces plane 1 and forces the top bit.
    for (genvar g = 0; g < PLANE_N; g++) begin : g_bit
        assign nib4[g] = planes_i[g];
        if (g == 0) begin : g_b0
            assign nib3[g] = planes_i[0];
        end else if (g == PLANE_N - 1) begin : g_top
            assign nib3[g] = 1'b1;
        end else begin : g_mid
            assign nib3[g] = planes_i[g + 1];
        end
    end

    // Widen the nibbles into indices.
    // The banked form takes its high bits from the attribute.
    always_comb begin
        planar4_o   = {{HI_W{1'b0}}, nib4};
        planar3_o   = {{HI_W{1'b0}}, nib3};
        planar256_o = {attr_i[HI_W-1:0], nib4};
    end
endmodule

// File: rtl/pcd_direct_unit.sv
// Direct colour selector.
// It handles the modes where a whole byte is the colour: single-layer ink,
// two-layer overlay and border only.
// Assumes: the lower layer has priority over the upper layer.
module pcd_direct_unit #(
    parameter int IDX_W = pcd_pkg::IDX_W
) (
    input  logic             lo_pix_i,
    input  logic             hi_pix_i,
    input  logic [IDX_W-1:0] lo_attr_i,
    input  logic [IDX_W-1:0] hi_attr_i,
    input  logic [IDX_W-1:0] border_i,
    output logic [IDX_W-1:0] ink256_o,
    output logic [IDX_W-1:0] layer256_o,
    output logic [IDX_W-1:0] border_o
);
    // A lit pixel takes the attribute; an unlit one falls back to the border.
    always_comb begin
        ink256_o = lo_pix_i ? lo_attr_i : border_i;
    end

    // Priority order: lower layer, then upper layer, then border.
    always_comb begin
        if (lo_pix_i)      layer256_o = lo_attr_i;
        else if (hi_pix_i) layer256_o = hi_attr_i;
        else               layer256_o = border_i;
    end

    // Border-only passes the border straight through.
    always_comb begin
        border_o = border_i;
    end
endmodule

// File: rtl/pix_colour_decoder.sv
// Pixel colour decoder, top level.
// It feeds one pixel's data to the three interpreters, picks the result
// named by the mode code and registers it.
// Assumes: all inputs belong to the same pixel and are valid in the same cycle.
// Reserved codes give index 0. Latency is one clock.
module pix_colour_decoder #(
    parameter int IDX_W   = pcd_pkg::IDX_W,
    parameter int ATTR_W  = pcd_pkg::ATTR_W,
    parameter int PLANE_N = pcd_pkg::PLANE_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PLANE_N-1:0] plane_bits,
    input  logic [ATTR_W-1:0]  attr_lo,
    input  logic [ATTR_W-1:0]  attr_hi,
    input  logic               flash_phase,
    input  logic [IDX_W-1:0]   border_idx,
    input  logic [3:0]         mode,
    output logic [IDX_W-1:0]   colour_idx
);
    import pcd_pkg::*;

    logic [IDX_W-1:0] classic_w, splitbr_w, c32_w, chunky_w;
    logic [IDX_W-1:0] p4_w, p3_w, p256_w;
    logic [IDX_W-1:0] ink_w, layer_w, brd_w;
    logic [IDX_W-1:0] next_idx;

    pcd_attr_unit #(.IDX_W(IDX_W), .ATTR_W(ATTR_W)) u_attr (
        .pix_i     (plane_bits[0]),
        .pair_i    (plane_bits[1:0]),
        .attr_i    (attr_lo),
        .phase_i   (flash_phase),
        .classic_o (classic_w),
        .splitbr_o (splitbr_w),
        .c32_o     (c32_w),
        .chunky_o  (chunky_w)
    );

    pcd_plane_unit #(.IDX_W(IDX_W), .ATTR_W(ATTR_W), .PLANE_N(PLANE_N)) u_plane (
        .planes_i    (plane_bits),
        .attr_i      (attr_lo),
        .planar4_o   (p4_w),
        .planar3_o   (p3_w),
        .planar256_o (p256_w)
    );

    pcd_direct_unit #(.IDX_W(IDX_W)) u_direct (
        .lo_pix_i   (plane_bits[0]),
        .hi_pix_i   (plane_bits[2]),
        .lo_attr_i  (attr_lo),
        .hi_attr_i  (attr_hi),
        .border_i   (border_idx),
        .ink256_o   (ink_w),
        .layer256_o (layer_w),
        .border_o   (brd_w)
    );

    // Pick the interpreter named by the mode code; reserved codes give zero.
    always_comb begin
        case (mode)
            4'(MODE_CLASSIC):   next_idx = classic_w;
            4'(MODE_SPLITBR):   next_idx = splitbr_w;
            4'(MODE_C32):       next_idx = c32_w;
            4'(MODE_INK256):    next_idx = ink_w;
            4'(MODE_LAYER256):  next_idx = layer_w;
            4'(MODE_PLANAR4):   next_idx = p4_w;
            4'(MODE_PLANAR3):   next_idx = p3_w;
            4'(MODE_PLANAR256): next_idx = p256_w;
            4'(MODE_BORDER):    next_idx = brd_w;
            4'(MODE_CHUNKY):    next_idx = chunky_w;
            default:            next_idx = '0;
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) colour_idx <= '0;
        else        colour_idx <= next_idx;
    end
endmodule

// File: rtl/pcd_checker.sv
// Assertion checker for pix_colour_decoder.
// It relates the registered index to the inputs of the previous cycle.
// It is attached to the top module by the bind at the end of this file.
module pcd_checker #(
    parameter int IDX_W   = pcd_pkg::IDX_W,
    parameter int ATTR_W  = pcd_pkg::ATTR_W,
    parameter int PLANE_N = pcd_pkg::PLANE_N
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PLANE_N-1:0] plane_bits,
    input logic [ATTR_W-1:0]  attr_lo,
    input logic [IDX_W-1:0]   border_idx,
    input logic [3:0]         mode,
    input logic [IDX_W-1:0]   colour_idx
);
    // R10: border-only mode follows the border colour.
    a_r10_border_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd13) |=> (colour_idx == $past(border_idx)));

    // R5: the 4-plane index is the plane nibble.
    a_r5_planar4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd6) |=> (colour_idx[3:0] == $past(plane_bits) && colour_idx[7:4] == 4'd0));

    // R6: the 3-plane index has its bit 3 forced and ignores plane 1.
    a_r6_planar3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd7) |=> (colour_idx[7:3] == 5'b00001 && colour_idx[0] == $past(plane_bits[0])));

    // R7: a lit pixel in 256-colour ink mode shows the attribute byte.
    a_r7_ink_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd4 && plane_bits[0]) |=> (colour_idx == $past(attr_lo)));

    // R12: reserved codes give zero.
    a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd3 || (mode >= 4'd8 && mode <= 4'd11) || mode == 4'd15) |=> (colour_idx == '0));
endmodule

bind pix_colour_decoder pcd_checker #(.IDX_W(IDX_W), .ATTR_W(ATTR_W), .PLANE_N(PLANE_N)) u_pcd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .plane_bits (plane_bits),
    .attr_lo    (attr_lo),
    .border_idx (border_idx),
    .mode       (mode),
    .colour_idx (colour_idx)
);

// File: tb/pix_colour_decoder_test.sv
// Bench for pix_colour_decoder.
// A behavioural model computes the index from the requirements. It is
// registered like the design and compared with the output on every falling edge.
module pix_colour_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] plane_bits = '0;
    logic [7:0] attr_lo = '0, attr_hi = '0, border_idx = '0;
    logic       flash_phase = 1'b0;
    logic [3:0] mode = '0;
    logic [7:0] colour_idx;

    int checks = 0, fails = 0;
    int expect_q = 0;

    always #2 clk = ~clk;

    pix_colour_decoder uut (
        .clk(clk), .rst_n(rst_n), .plane_bits(plane_bits), .attr_lo(attr_lo),
        .attr_hi(attr_hi), .flash_phase(flash_phase), .border_idx(border_idx),
        .mode(mode), .colour_idx(colour_idx)
    );

    // Requirement tag for a mode code.
    function automatic string tag_of(input int m);
        case (m)
            0: return "R2";  1: return "R3";  2: return "R4";  4: return "R7";
            5: return "R8";  6: return "R5";  7: return "R6";  12: return "R9";
            13: return "R10"; 14: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Behavioural model of the index, written arithmetically.
    function automatic int model(input int m, input int pl, input int a, input int ah,
                                 input int ph, input int brd);
        int p0 = pl % 2, p1 = (pl / 2) % 2, p2 = (pl / 4) % 2, p3 = (pl / 8) % 2;
        int ink = a % 8, pap = (a / 8) % 8, b6 = (a / 64) % 2, b7 = a / 128, t;
        case (m)
            0: begin
                if (b7 == 1 && ph == 1) begin t = ink; ink = pap; pap = t; end
                return (p0 == 1 ? ink : pap) + 8 * b6;
            end
            1: return p0 == 1 ? ink + 8 * b6 : pap + 8 * b7;
            2: return (p0 == 1 ? ink : pap) + 8 * (a / 64);
            4: return p0 == 1 ? a : brd;
            5: return p0 == 1 ? a : (p2 == 1 ? ah : brd);
            6: return pl;
            7: return 8 + 4 * p3 + 2 * p2 + p0;
            12: return (a % 16) * 16 + pl;
            13: return brd;
            14: case (p1 * 2 + p0)
                    0: return pap + 8 * b6;
                    1: return ink + 16;
                    2: return ink + 24;
                    default: return ink + 8;
                endcase
            default: return 0;
        endcase
    endfunction

    // Reference register: mirrors the one-cycle latency and reset of R1.
    always @(posedge clk) begin
        if (!rst_n) expect_q <= 0;
        else expect_q <= model(int'(mode), int'(plane_bits), int'(attr_lo), int'(attr_hi),
                               int'(flash_phase), int'(border_idx));
    end

    task automatic check(input string req);
        checks++;
        if (int'(colour_idx) != expect_q) begin
            fails++;
            $display("FAIL %s mode=%0d got=%0d expected=%0d", req, mode, colour_idx, expect_q);
        end
    endtask

    // Apply one vector at a falling edge.
    // At the next falling edge, check it and name its requirement.
    task automatic apply(input int m, input int pl, input int a, input int ah,
                         input int ph, input int brd);
        mode = 4'(m); plane_bits = 4'(pl); attr_lo = 8'(a); attr_hi = 8'(ah);
        flash_phase = ph[0]; border_idx = 8'(brd);
        @(negedge clk);
        check(tag_of(m));
    endtask

    initial begin
        @(negedge clk);
        apply(13, 0, 0, 0, 0, 8'hA5);   // in reset: R1 output is 0
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        // R1 latency and R5 example: planes 0..3 = 1,0,1,1 give 13
        apply(6, 4'b1101, 0, 0, 0, 0);
        // R2 classic: ink 5, paper 2, bright, flash off then on with phase 1
        apply(0, 1, 8'b0101_0101, 0, 1, 0);
        apply(0, 1, 8'b1101_0101, 0, 1, 0);
        apply(0, 0, 8'b1101_0101, 0, 1, 0);
        apply(0, 0, 8'b1101_0101, 0, 0, 0);
        // R3 split bright, flash has no effect
        apply(1, 1, 8'b1001_0011, 0, 1, 0);
        apply(1, 0, 8'b1001_0011, 0, 1, 0);
        // R4 32 colour
        apply(2, 1, 8'hC6, 0, 1, 0);
        apply(2, 0, 8'h7E, 0, 0, 0);
        // R6 3-plane, plane 1 ignored
        apply(7, 4'b0010, 0, 0, 0, 0);
        apply(7, 4'b1101, 0, 0, 0, 0);
        // R7 ink256 lit and unlit
        apply(4, 1, 8'h9C, 0, 0, 8'h33);
        apply(4, 0, 8'h9C, 0, 0, 8'h33);
        // R8 priority: both lit, upper only, none
        apply(5, 4'b0101, 8'h11, 8'h22, 0, 8'h33);
        apply(5, 4'b0100, 8'h11, 8'h22, 0, 8'h33);
        apply(5, 4'b0000, 8'h11, 8'h22, 0, 8'h33);
        // R9 planar256 bank from low nibble
        apply(12, 4'b1010, 8'hF7, 0, 0, 0);
        // R10 border only with lit pixels
        apply(13, 4'hF, 8'hFF, 8'hFF, 1, 8'h5A);
        // R11 all four pairs with flash set
        for (int p = 0; p < 4; p++) apply(14, p, 8'b1110_1011, 0, 1, 0);
        // R12 each reserved code
        apply(3, 4'hF, 8'hFF, 8'hFF, 1, 8'hFF);
        for (int r = 8; r < 12; r++) apply(r, 4'hF, 8'hFF, 8'hFF, 1, 8'hFF);
        apply(15, 4'hF, 8'hFF, 8'hFF, 1, 8'hFF);
        // Random sweep over all modes
        for (int i = 0; i < 4000; i++)
            apply(int'($urandom_range(15)), int'($urandom_range(15)), int'($urandom_range(255)),
                  int'($urandom_range(255)), int'($urandom_range(1)), int'($urandom_range(255)));
        // R1 reset in mid run
        mode = 4'd13; border_idx = 8'hEE; rst_n = 1'b0;
        @(negedge clk);
        check("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired got=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule